// File: doc/BRIEF.md
# ULPI PHY Low-Power and Serial-Mode Sequencer

This block sits on the PHY side of a ULPI link. It moves the interface between normal synchronous operation, a low-power suspend state and two legacy full/low-speed serial formats (a 3-pin and a 6-pin variant). It holds the mode-related bits of the Function Control and Interface Control registers and watches the register writes that the command decoder forwards. When a write sets a mode bit, the block waits a fixed number of cycles and then takes the bus: it raises DIR and drops the enable of the 60 MHz interface clock gate.

While a mode is active, the link wakes the PHY by raising STP. The block treats STP as asynchronous and resynchronises it on the free-running oscillator clock that it runs on, because the interface clock is stopped at that point. On a wake it restarts the clock, keeps DIR high for a start-up interval and then releases DIR. It returns to synchronous operation only after the link lowers STP. This also covers a link that is reset while the PHY sleeps, since STP is then held high by the link or by the pull-up. The mode bits clear themselves on exit. A separate Interface Control bit keeps the clock running through a serial mode, and another bit switches off the STP pull-up.

Top module: `ulpi_suspend_seq`

## Requirements
- R1: During and right after a synchronous reset, dir_o=0, clk_en_o=1, sync_ok_o=1, mode_o=0, pullup_en_o=1, and both register read-backs are 0x00.
- R2: A write to address 0x04 (Function Control) with data bit 6 set starts low-power entry. sync_ok_o drops on the write edge. Exactly ENTRY_CYCLES (default 5) clock edges after that write edge, dir_o rises, clk_en_o falls and mode_o becomes 1. Until then dir_o stays 0.
- R3: A write to address 0x07 (Interface Control) with data bit 1 set enters the 3-pin serial mode with the same timing as R2, with mode_o=2. If bit 3 is clear, clk_en_o falls.
- R4: A write to address 0x07 with data bit 0 set enters the 6-pin serial mode with the same timing, with mode_o=3.
- R5: When Interface Control bit 3 is set on entry to a serial mode, clk_en_o stays 1 for the whole time in that mode.
- R6: If bits 0 and 1 are set in the same write, the 3-pin mode (mode_o=2) wins. A Function Control low-power request would outrank both.
- R7: In any mode, STP held high is seen after two synchroniser edges. On the next edge, clk_en_o rises and mode_o returns to 0 while dir_o stays 1. dir_o falls RESTART_CYCLES (default 3) edges later.
- R8: After dir_o falls, sync_ok_o stays 0 for as long as STP stays high, however long that is (the warm-reset case). sync_ok_o returns to 1 on the third edge after STP goes low.
- R9: Leaving a mode clears Interface Control bits 0 and 1 and Function Control bit 6. Interface Control bits 3 and 7 are kept.
- R10: pullup_en_o is the inverse of Interface Control bit 7.
- R11: STP has no effect in normal operation. Register writes made outside normal operation change neither register.
- R12: A write whose mode bits are all zero starts no entry: dir_o stays 0 and sync_ok_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | One-cycle strobe of a completed register write |
| reg_wr_addr | input | ADDR_W | Register address of that write |
| reg_wr_data | input | 8 | Data of that write |
| stp_i | input | 1 | STP from the link, asynchronous while suspended |
| dir_o | output | 1 | DIR to the link |
| clk_en_o | output | 1 | Enable for the interface clock gate |
| sync_ok_o | output | 1 | High while synchronous ULPI operation is allowed |
| mode_o | output | 2 | 0 sync/transition, 1 low power, 2 serial 3-pin, 3 serial 6-pin |
| pullup_en_o | output | 1 | Enables the STP pull-up |
| ifc_ctrl_o | output | 8 | Interface Control read-back |
| func_ctrl_o | output | 8 | Function Control read-back |

## Verification
The hardest case to reach is the warm-reset wake. STP has to be held high across the whole restart interval and beyond the fall of DIR. The bench must then show that synchronous operation stays withheld until STP is released, and that it returns after exactly the synchroniser delay. To get there, the bench first enters each mode through a register write, then raises STP and holds it for a chosen number of extra cycles before releasing it. The scoreboard carries cycle-exact expectations for every stage of entry, wake and release. Writes issued while suspended are checked through the register read-back once the block is awake again.

// File: rtl/ulpi_susp_pkg.sv
package ulpi_susp_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL, ST_ENTRY_WAIT, ST_SUSPENDED, ST_SERIAL_3PIN,
    ST_SERIAL_6PIN, ST_RESTART, ST_WAIT_STP_LOW
  } seq_state_e;

  typedef enum logic [1:0] {
    MODE_SYNC = 2'd0, MODE_LOWPWR = 2'd1, MODE_SER3 = 2'd2, MODE_SER6 = 2'd3
  } link_mode_e;

  localparam int IFC_SER6_BIT    = 0;
  localparam int IFC_SER3_BIT    = 1;
  localparam int IFC_KEEPCLK_BIT = 3;
  localparam int IFC_PROTDIS_BIT = 7;
  localparam int FUNC_LOWPWR_BIT = 6;
endpackage

// File: rtl/ulpi_stp_sync.sv
module ulpi_stp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  generate
    if (STAGES < 2) begin : g_single
      logic flop_q;
      always_ff @(posedge clk) begin
        if (rst) flop_q <= 1'b0;
        else     flop_q <= async_in;
      end
      assign sync_out = flop_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_in};
      end
      assign sync_out = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ulpi_mode_regs.sv
module ulpi_mode_regs
  import ulpi_susp_pkg::*;
#(
  parameter int               ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] FUNC_ADDR = 6'h04,
  parameter logic [ADDR_W-1:0] IFC_ADDR  = 6'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wr_allow,
  input  logic              clr_modes,
  output logic [7:0]        ifc_q,
  output logic [7:0]        func_q,
  output logic              req_valid,
  output link_mode_e        req_mode
);
  logic hit_ifc, hit_func;
  assign hit_ifc  = wr_en && wr_allow && (wr_addr == IFC_ADDR);
  assign hit_func = wr_en && wr_allow && (wr_addr == FUNC_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ifc_q  <= 8'h00;
      func_q <= 8'h00;
    end else if (clr_modes) begin
      ifc_q[IFC_SER6_BIT]     <= 1'b0;
      ifc_q[IFC_SER3_BIT]     <= 1'b0;
      func_q[FUNC_LOWPWR_BIT] <= 1'b0;
    end else begin
      if (hit_ifc)  ifc_q  <= wr_data;
      if (hit_func) func_q <= wr_data;
    end
  end

  // Priority: low power, then 3-pin, then 6-pin serial.
  always_comb begin
    req_valid = 1'b0;
    req_mode  = MODE_SYNC;
    if (hit_func && wr_data[FUNC_LOWPWR_BIT]) begin
      req_valid = 1'b1;
      req_mode  = MODE_LOWPWR;
    end else if (hit_ifc && wr_data[IFC_SER3_BIT]) begin
      req_valid = 1'b1;
      req_mode  = MODE_SER3;
    end else if (hit_ifc && wr_data[IFC_SER6_BIT]) begin
      req_valid = 1'b1;
      req_mode  = MODE_SER6;
    end
  end

  // R11: registers frozen when writes are locked out and nothing clears them
  p_locked_regs_r11: assert property (@(posedge clk) disable iff (rst)
    (!wr_allow && !clr_modes) |=> ($stable(ifc_q) && $stable(func_q)));
endmodule

// File: rtl/ulpi_mode_timer.sv
module ulpi_mode_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] term,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign expire = !start && (cnt_q == term);
endmodule

// File: rtl/ulpi_suspend_seq.sv
module ulpi_suspend_seq
  import ulpi_susp_pkg::*;
#(
  parameter int ADDR_W         = 6,
  parameter int FUNC_ADDR      = 4,
  parameter int IFC_ADDR       = 7,
  parameter int ENTRY_CYCLES   = 5,
  parameter int RESTART_CYCLES = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [7:0]        reg_wr_data,
  input  logic              stp_i,
  output logic              dir_o,
  output logic              clk_en_o,
  output logic              sync_ok_o,
  output logic [1:0]        mode_o,
  output logic              pullup_en_o,
  output logic [7:0]        ifc_ctrl_o,
  output logic [7:0]        func_ctrl_o
);
  localparam int MAX_CYC = (ENTRY_CYCLES > RESTART_CYCLES) ? ENTRY_CYCLES : RESTART_CYCLES;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] ENTRY_TC   = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] RESTART_TC = CNT_W'(RESTART_CYCLES - 1);

  seq_state_e state_q, state_n;
  link_mode_e pend_q, req_mode, mode_q;
  logic       stp_s, req_valid, tmr_start, tmr_expire, in_mode, wr_allow;
  logic [7:0] ifc_q, func_q;

  ulpi_stp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(stp_i), .sync_out(stp_s));

  assign in_mode  = (state_q == ST_SUSPENDED) || (state_q == ST_SERIAL_3PIN) ||
                    (state_q == ST_SERIAL_6PIN);
  assign wr_allow = (state_q == ST_NORMAL);

  ulpi_mode_regs #(
    .ADDR_W(ADDR_W), .FUNC_ADDR(ADDR_W'(FUNC_ADDR)), .IFC_ADDR(ADDR_W'(IFC_ADDR))
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .wr_allow(wr_allow), .clr_modes(in_mode && stp_s),
    .ifc_q(ifc_q), .func_q(func_q), .req_valid(req_valid), .req_mode(req_mode));

  assign tmr_start = (wr_allow && req_valid) || (in_mode && stp_s);

  ulpi_mode_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start),
    .term((state_q == ST_RESTART) ? RESTART_TC : ENTRY_TC), .expire(tmr_expire));

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_NORMAL:     if (req_valid) state_n = ST_ENTRY_WAIT;
      ST_ENTRY_WAIT: if (tmr_expire) begin
        unique case (pend_q)
          MODE_SER3: state_n = ST_SERIAL_3PIN;
          MODE_SER6: state_n = ST_SERIAL_6PIN;
          default:   state_n = ST_SUSPENDED;
        endcase
      end
      ST_SUSPENDED, ST_SERIAL_3PIN, ST_SERIAL_6PIN:
                       if (stp_s) state_n = ST_RESTART;
      ST_RESTART:      if (tmr_expire) state_n = ST_WAIT_STP_LOW;
      ST_WAIT_STP_LOW: if (!stp_s) state_n = ST_NORMAL;
      default:         state_n = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_NORMAL;
      pend_q    <= MODE_SYNC;
      dir_o     <= 1'b0;
      clk_en_o  <= 1'b1;
      sync_ok_o <= 1'b1;
      mode_q    <= MODE_SYNC;
    end else begin
      state_q <= state_n;
      if (wr_allow && req_valid) pend_q <= req_mode;
      dir_o     <= (state_n == ST_SUSPENDED) || (state_n == ST_SERIAL_3PIN) ||
                   (state_n == ST_SERIAL_6PIN) || (state_n == ST_RESTART);
      clk_en_o  <= !((state_n == ST_SUSPENDED) ||
                     (((state_n == ST_SERIAL_3PIN) || (state_n == ST_SERIAL_6PIN)) &&
                      !ifc_q[IFC_KEEPCLK_BIT]));
      sync_ok_o <= (state_n == ST_NORMAL);
      unique case (state_n)
        ST_SUSPENDED:   mode_q <= MODE_LOWPWR;
        ST_SERIAL_3PIN: mode_q <= MODE_SER3;
        ST_SERIAL_6PIN: mode_q <= MODE_SER6;
        default:        mode_q <= MODE_SYNC;
      endcase
    end
  end

  assign mode_o      = mode_q;
  assign pullup_en_o = !ifc_q[IFC_PROTDIS_BIT];
  assign ifc_ctrl_o  = ifc_q;
  assign func_ctrl_o = func_q;

  // R2: low power always means DIR held and clock stopped
  p_lowpwr_stops_clk_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LOWPWR) |-> (dir_o && !clk_en_o));
  // R2: DIR only rises right after the entry timer expires
  p_dir_after_wait_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(dir_o) |-> $past(tmr_expire));
  // R5: keep-clock bit holds the clock through serial modes
  p_keep_clk_r5: assert property (@(posedge clk) disable iff (rst)
    (((mode_q == MODE_SER3) || (mode_q == MODE_SER6)) && ifc_q[IFC_KEEPCLK_BIT]) |-> clk_en_o);
  // R9: mode bits are already cleared while restarting
  p_exit_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RESTART) |-> ((ifc_q[1:0] == 2'b00) && !func_q[FUNC_LOWPWR_BIT]));
  // R8: no synchronous operation while STP is still high after release of DIR
  p_hold_until_stp_low_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_STP_LOW) |-> (!sync_ok_o && !dir_o && clk_en_o));
endmodule

// File: tb/tb_ulpi_suspend_seq.sv
module tb_ulpi_suspend_seq;
  import ulpi_susp_pkg::*;
  localparam int ENTRY = 5;
  localparam int RESTART = 3;
  localparam logic [5:0] A_FUNC = 6'h04;
  localparam logic [5:0] A_IFC  = 6'h07;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [5:0] reg_wr_addr = '0;
  logic [7:0] reg_wr_data = '0;
  logic stp_i = 1'b0;
  logic dir_o, clk_en_o, sync_ok_o, pullup_en_o;
  logic [1:0] mode_o;
  logic [7:0] ifc_ctrl_o, func_ctrl_o;

  always #4 clk = ~clk;

  ulpi_suspend_seq dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .stp_i(stp_i), .dir_o(dir_o), .clk_en_o(clk_en_o),
    .sync_ok_o(sync_ok_o), .mode_o(mode_o), .pullup_en_o(pullup_en_o),
    .ifc_ctrl_o(ifc_ctrl_o), .func_ctrl_o(func_ctrl_o));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int t; logic d; logic ce; logic so; logic [1:0] md; string tag;
  } exp_t;
  exp_t sb_q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(input int t, input logic d, input logic ce, input logic so,
                      input logic [1:0] md, input string tag);
    exp_t e;
    e.t = t; e.d = d; e.ce = ce; e.so = so; e.md = md; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: pops expected items at their cycle and compares the outputs
  always @(negedge clk) begin
    exp_t e;
    while (sb_q.size() > 0 && sb_q[0].t < cyc) begin
      e = sb_q.pop_front();
      chk(1'b0, e.tag, "missed sample", cyc, e.t);
    end
    while (sb_q.size() > 0 && sb_q[0].t == cyc) begin
      e = sb_q.pop_front();
      chk({dir_o, clk_en_o, sync_ok_o, mode_o} == {e.d, e.ce, e.so, e.md}, e.tag,
          "dir/clk_en/sync_ok/mode", int'({dir_o, clk_en_o, sync_ok_o, mode_o}),
          int'({e.d, e.ce, e.so, e.md}));
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] dat);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = dat;
    tick();
    reg_wr_en = 1'b0;
  endtask

  task automatic hold(input int n, input logic d, input logic ce, input logic so,
                      input logic [1:0] md, input string tag);
    for (int i = 1; i <= n; i++) push(cyc + i, d, ce, so, md, tag);
    repeat (n) tick();
  endtask

  task automatic enter(input logic [5:0] a, input logic [7:0] dat, input logic [1:0] md,
                       input logic ce, input string tag);
    int k;
    k = cyc + 1;
    for (int i = 0; i < ENTRY; i++) push(k + i, 1'b0, 1'b1, 1'b0, MODE_SYNC, tag);
    push(k + ENTRY, 1'b1, ce, 1'b0, md, tag);
    wr(a, dat);
    repeat (ENTRY) tick();
  endtask

  task automatic wake(input logic [1:0] md, input logic ce, input int extra,
                      input string tag);
    int c, d;
    c = cyc;
    stp_i = 1'b1;
    push(c + 1, 1'b1, ce, 1'b0, md, tag);
    push(c + 2, 1'b1, ce, 1'b0, md, tag);
    for (int i = 0; i < RESTART; i++) push(c + 3 + i, 1'b1, 1'b1, 1'b0, MODE_SYNC, tag);
    for (int j = 0; j < extra; j++)
      push(c + 3 + RESTART + j, 1'b0, 1'b1, 1'b0, MODE_SYNC, "R8");
    d = c + 2 + RESTART + extra;
    repeat (d - c) tick();
    stp_i = 1'b0;
    push(d + 1, 1'b0, 1'b1, 1'b0, MODE_SYNC, "R8");
    push(d + 2, 1'b0, 1'b1, 1'b0, MODE_SYNC, "R8");
    push(d + 3, 1'b0, 1'b1, 1'b1, MODE_SYNC, "R8");
    repeat (4) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired, queue=%0d", sb_q.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk(dir_o == 1'b0 && clk_en_o && sync_ok_o, "R1", "reset outputs",
        int'({dir_o, clk_en_o, sync_ok_o}), 3);
    rst = 1'b0;
    tick();
    chk({dir_o, clk_en_o, sync_ok_o, mode_o} == 5'b01100, "R1", "post-reset outputs",
        int'({dir_o, clk_en_o, sync_ok_o, mode_o}), 5'b01100);
    chk(pullup_en_o == 1'b1, "R1", "pullup", pullup_en_o, 1);
    chk(ifc_ctrl_o == 8'h00 && func_ctrl_o == 8'h00, "R1", "regs",
        int'({ifc_ctrl_o, func_ctrl_o}), 0);

    // R11: STP in normal operation has no effect
    stp_i = 1'b1;
    hold(8, 1'b0, 1'b1, 1'b1, MODE_SYNC, "R11");
    stp_i = 1'b0;
    hold(4, 1'b0, 1'b1, 1'b1, MODE_SYNC, "R11");

    // R10 and R12: protect-disable write, no mode bits
    wr(A_IFC, 8'h80);
    chk(pullup_en_o == 1'b0, "R10", "pullup off", pullup_en_o, 0);
    hold(8, 1'b0, 1'b1, 1'b1, MODE_SYNC, "R12");
    wr(A_IFC, 8'h00);
    chk(pullup_en_o == 1'b1, "R10", "pullup on", pullup_en_o, 1);

    // R2: low power entry
    enter(A_FUNC, 8'h40, MODE_LOWPWR, 1'b0, "R2");
    chk(func_ctrl_o == 8'h40, "R2", "func reg", func_ctrl_o, 8'h40);
    // R11: write while suspended is ignored
    push(cyc + 1, 1'b1, 1'b0, 1'b0, MODE_LOWPWR, "R11");
    push(cyc + 2, 1'b1, 1'b0, 1'b0, MODE_LOWPWR, "R11");
    wr(A_IFC, 8'h83);
    tick();
    chk(ifc_ctrl_o == 8'h00, "R11", "ifc after locked write", ifc_ctrl_o, 0);
    // R7/R8: warm-reset style wake with STP held long
    wake(MODE_LOWPWR, 1'b0, 10, "R7");
    chk(func_ctrl_o == 8'h00, "R9", "func after exit", func_ctrl_o, 0);
    chk(ifc_ctrl_o == 8'h00, "R11", "ifc after wake", ifc_ctrl_o, 0);

    // R3: 3-pin serial, clock stopped
    enter(A_IFC, 8'h02, MODE_SER3, 1'b0, "R3");
    wake(MODE_SER3, 1'b0, 2, "R7");
    chk(ifc_ctrl_o == 8'h00, "R9", "ifc after 3-pin exit", ifc_ctrl_o, 0);

    // R4/R5: 6-pin serial with keep-clock bit
    enter(A_IFC, 8'h09, MODE_SER6, 1'b1, "R4");
    hold(6, 1'b1, 1'b1, 1'b0, MODE_SER6, "R5");
    wake(MODE_SER6, 1'b1, 1, "R7");
    chk(ifc_ctrl_o == 8'h08, "R9", "ifc keeps bit3", ifc_ctrl_o, 8'h08);

    // R6: both serial bits, 3-pin wins; bit 7 kept across exit
    enter(A_IFC, 8'h83, MODE_SER3, 1'b0, "R6");
    chk(pullup_en_o == 1'b0, "R10", "pullup off in mode", pullup_en_o, 0);
    wake(MODE_SER3, 1'b0, 1, "R7");
    chk(ifc_ctrl_o == 8'h80, "R9", "ifc keeps bit7", ifc_ctrl_o, 8'h80);

    while (sb_q.size() > 0) tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule